// File: doc/BRIEF.md
# GF(2^m) Edge Permute/Depermute Unit

This block reorders the probability entries of one message per Tanner-graph edge in a non-binary LDPC decoder. Each edge carries a nonzero field coefficient h = α^k in GF(2^m). In permute mode, used on variable-to-check messages, the entry for symbol x moves to the position of the product h·x. In depermute mode, used on check-to-variable messages, the move uses h⁻¹, so a depermute undoes a permute done with the same coefficient. The entry values are never altered. Only their positions change.

A run starts with a one-cycle `start`, a direction on `mode` and an edge count. For each edge in ascending order, the unit reads all q = 2^m entries in one access from a memory split into q banks. It reads the coefficient exponent for that edge from an external lookup table in the same cycle. The unit holds the entries in a buffer for one cycle, then writes them back in the new order to the same address. When the last edge is written, `done` pulses.

The field uses the primitive polynomial x^m + x + 1, which the block supports for m = 2, 3 and 4. The off-line construction of the coefficient table is left to the user.

Top module: `edge_perm_unit`

## Requirements
- R1: After a cycle with `rst_n` low, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: In permute mode (`mode`=0), for an edge with exponent k, the written lane h·x holds the read lane x. Here h = α^k, α is a root of x^m + x + 1, and lane j is bits [j·DATA_W +: DATA_W] of the data buses. The values are passed through unchanged.
- R3: In depermute mode (`mode`=1), the written lane h⁻¹·x holds the read lane x. A depermute run with the same table therefore restores the data as it was before a permute run.
- R4: Lane 0, which holds the zero symbol, is always written back to lane 0, in both modes and for every exponent.
- R5: The exponent is taken modulo q−1. Exponents 0 and q−1 both give the identity ordering.
- R6: Edge e is read at address e and written at address e two cycles later. Edges are handled in the order 0 to n−1, each one taking three cycles. A read and a write never happen in the same cycle.
- R7: `done` is high for exactly one cycle, 3·n cycles after the cycle in which `start` is accepted. `busy` is low while `done` is high. When n = 0, `done` follows at once and the memory is not accessed.
- R8: `start` is ignored while `busy` or `done` is high. No extra run and no extra memory write result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a run when the unit is idle |
| mode | input | 1 | 0 = permute, 1 = depermute; sampled with start |
| n_edges | input | EDGE_W | Number of edges in the run; sampled with start |
| busy | output | 1 | High while edges are being processed |
| done | output | 1 | One-cycle pulse at the end of a run |
| coef_addr | output | EDGE_W | Edge index presented to the coefficient table |
| coef_exp | input | GF_M | Exponent k of the edge coefficient, valid one cycle after a read |
| mem_addr | output | EDGE_W | Edge index for the banked message memory |
| mem_rd_en | output | 1 | Read of all q banks at mem_addr |
| mem_rd_data | input | Q·DATA_W | The q entries, valid one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Write of all q banks at mem_addr |
| mem_wr_data | output | Q·DATA_W | The reordered entries |

## Verification
The collision of interest is a new `start` that arrives while a run is active, including in the single cycle in which `done` is high. The unit is about to return to idle in that cycle, so a careless design could begin a new run there. The bench holds `start` high from the start of a run through its `done` cycle and drops it one cycle later. It then checks three things: the memory received exactly n writes in ascending order, `busy` stays low afterwards, and the data match one reordering and not two.

// File: rtl/gf_perm_pkg.sv
// Package: shared state type and constant GF(2^m) table builders.
// Assumes m in 2..4 with primitive polynomial x^m + x + 1.
package gf_perm_pkg;

    localparam int MAX_M = 4;
    localparam int MAX_Q = 16;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_READ = 3'd1,
        ST_LOAD = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE = 3'd4
    } perm_state_t;

    // Multiply a field element by alpha (shift and reduce by x^m+x+1).
    function automatic int gf_times_alpha(input int v, input int m);
        int r;
        r = v << 1;
        if ((r & (1 << m)) != 0) begin
            r = (r ^ (1 << m)) ^ 3;
        end
        return r;
    endfunction

    // Antilog table: nibble i holds alpha^i, for i in 0..q-2.
    function automatic logic [MAX_Q*MAX_M-1:0] gf_alog_table(input int m);
        logic [MAX_Q*MAX_M-1:0] tab;
        int v;
        tab = '0;
        v = 1;
        for (int i = 0; i < (1 << m) - 1; i++) begin
            tab[i*MAX_M +: MAX_M] = MAX_M'(v);
            v = gf_times_alpha(v, m);
        end
        return tab;
    endfunction

    // Logarithm of a nonzero element y (returns 0 for y = 0 or 1).
    function automatic int gf_log(input int y, input int m);
        int v;
        int res;
        v = 1;
        res = 0;
        for (int i = 0; i < (1 << m) - 1; i++) begin
            if (v == y) begin
                res = i;
            end
            v = gf_times_alpha(v, m);
        end
        return res;
    endfunction

endpackage

// File: rtl/edge_perm_ctrl.sv
// Module: edge_perm_ctrl
// Sequences a run: one read, one load and one write cycle per edge.
// Edges run from 0 to n-1. Assumes the memory and the table answer
// one cycle after a read.
module edge_perm_ctrl
    import gf_perm_pkg::*;
#(
    parameter int EDGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_in,
    input  logic [EDGE_W-1:0] n_edges,
    output logic              mode_q,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              rd_en,
    output logic              load_en,
    output logic              wr_en,
    output logic              busy,
    output logic              done
);

    perm_state_t       state;
    logic [EDGE_W-1:0] n_q;
    logic [EDGE_W-1:0] idx_next;

    assign idx_next = edge_idx + 1'b1;

    // State, edge counter and latched run settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            edge_idx <= '0;
            n_q      <= '0;
            mode_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= mode_in;
                        n_q      <= n_edges;
                        edge_idx <= '0;
                        state    <= (n_edges == '0) ? ST_DONE : ST_READ;
                    end
                end
                ST_READ:  state <= ST_LOAD;
                ST_LOAD:  state <= ST_WRITE;
                ST_WRITE: begin
                    if (idx_next == n_q) begin
                        state <= ST_DONE;
                    end else begin
                        edge_idx <= idx_next;
                        state    <= ST_READ;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Decoded strobes for the datapath and the ports.
    always_comb begin
        rd_en   = (state == ST_READ);
        load_en = (state == ST_LOAD);
        wr_en   = (state == ST_WRITE);
        busy    = (state == ST_READ) || (state == ST_LOAD) || (state == ST_WRITE);
        done    = (state == ST_DONE);
    end

endmodule

// File: rtl/edge_perm_buffer.sv
// Module: edge_perm_buffer
// Holds one edge's q entries and its exponent reduced modulo q-1.
// Assumes the data and the exponent are valid in the load cycle.
module edge_perm_buffer #(
    parameter int GF_M   = 3,
    parameter int DATA_W = 8,
    localparam int Q     = 1 << GF_M
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [Q*DATA_W-1:0] rd_data,
    input  logic [GF_M-1:0]     exp_in,
    output logic [Q*DATA_W-1:0] buf_data,
    output logic [GF_M-1:0]     exp_q
);

    localparam int QM1 = Q - 1;

    logic [GF_M-1:0] exp_red;

    // Reduce the exponent: it is below 2*(q-1), so one subtraction suffices.
    always_comb begin
        if (int'(exp_in) >= QM1) begin
            exp_red = exp_in - GF_M'(QM1);
        end else begin
            exp_red = exp_in;
        end
    end

    // Capture the entries and the reduced exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            exp_q    <= '0;
        end else if (load_en) begin
            buf_data <= rd_data;
            exp_q    <= exp_red;
        end
    end

endmodule

// File: rtl/edge_perm_xbar.sv
// Module: edge_perm_xbar
// Reorders the entries. Output lane y takes input lane alpha^(log y - k)
// in permute mode and alpha^(log y + k) in depermute mode. Lane 0 passes
// straight through. Assumes exp_k < q-1.
module edge_perm_xbar
    import gf_perm_pkg::*;
#(
    parameter int GF_M   = 3,
    parameter int DATA_W = 8,
    localparam int Q     = 1 << GF_M
) (
    input  logic                mode,
    input  logic [GF_M-1:0]     exp_k,
    input  logic [Q*DATA_W-1:0] din,
    output logic [Q*DATA_W-1:0] dout
);

    localparam int QM1 = Q - 1;
    localparam logic [MAX_Q*MAX_M-1:0] ALOG = gf_alog_table(GF_M);

    logic [GF_M-1:0] shift;

    // Exponent shift: -k mod (q-1) for permute, +k for depermute.
    always_comb begin
        if (mode) begin
            shift = exp_k;
        end else if (exp_k == '0) begin
            shift = '0;
        end else begin
            shift = GF_M'(QM1) - exp_k;
        end
    end

    assign dout[DATA_W-1:0] = din[DATA_W-1:0];

    for (genvar y = 1; y < Q; y++) begin : g_lane
        localparam int LOG_Y = gf_log(y, GF_M);
        logic [GF_M:0]   sum;
        logic [GF_M-1:0] src_log;
        logic [GF_M-1:0] src;

        // Source lane of output lane y.
        always_comb begin
            sum = (GF_M+1)'(LOG_Y) + {1'b0, shift};
            if (int'(sum) >= QM1) begin
                src_log = GF_M'(int'(sum) - QM1);
            end else begin
                src_log = sum[GF_M-1:0];
            end
            src = ALOG[int'(src_log)*MAX_M +: GF_M];
        end

        assign dout[y*DATA_W +: DATA_W] = din[int'(src)*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/edge_perm_unit.sv
// Module: edge_perm_unit (top)
// Permutes or depermutes the q-entry message of every edge in place.
// The reordering comes from the edge's GF(2^m) coefficient. Assumes a
// memory split into q banks and a coefficient table, both read with one
// cycle of latency.
module edge_perm_unit #(
    parameter int GF_M   = 3,
    parameter int DATA_W = 8,
    parameter int EDGE_W = 8,
    localparam int Q     = 1 << GF_M
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode,
    input  logic [EDGE_W-1:0]   n_edges,
    output logic                busy,
    output logic                done,
    output logic [EDGE_W-1:0]   coef_addr,
    input  logic [GF_M-1:0]     coef_exp,
    output logic [EDGE_W-1:0]   mem_addr,
    output logic                mem_rd_en,
    input  logic [Q*DATA_W-1:0] mem_rd_data,
    output logic                mem_wr_en,
    output logic [Q*DATA_W-1:0] mem_wr_data
);

    logic              mode_q;
    logic [EDGE_W-1:0] edge_idx;
    logic              load_en;
    logic [Q*DATA_W-1:0] buf_data;
    logic [GF_M-1:0]   exp_q;

    edge_perm_ctrl #(.EDGE_W(EDGE_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_in  (mode),
        .n_edges  (n_edges),
        .mode_q   (mode_q),
        .edge_idx (edge_idx),
        .rd_en    (mem_rd_en),
        .load_en  (load_en),
        .wr_en    (mem_wr_en),
        .busy     (busy),
        .done     (done)
    );

    edge_perm_buffer #(.GF_M(GF_M), .DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .rd_data  (mem_rd_data),
        .exp_in   (coef_exp),
        .buf_data (buf_data),
        .exp_q    (exp_q)
    );

    edge_perm_xbar #(.GF_M(GF_M), .DATA_W(DATA_W)) u_xbar (
        .mode  (mode_q),
        .exp_k (exp_q),
        .din   (buf_data),
        .dout  (mem_wr_data)
    );

    assign mem_addr  = edge_idx;
    assign coef_addr = edge_idx;

endmodule

// File: rtl/edge_perm_checker.sv
// Module: edge_perm_checker
// Temporal properties of edge_perm_unit, attached through bind.
module edge_perm_checker #(
    parameter int GF_M   = 3,
    parameter int DATA_W = 8,
    parameter int EDGE_W = 8,
    localparam int Q     = 1 << GF_M
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic [EDGE_W-1:0]   mem_addr,
    input logic                mem_rd_en,
    input logic [Q*DATA_W-1:0] mem_rd_data,
    input logic                mem_wr_en,
    input logic [Q*DATA_W-1:0] mem_wr_data
);

    logic [DATA_W-1:0] xor_rd;
    logic [DATA_W-1:0] xor_wr;

    // XOR of all lanes on each bus, used to check that the values are kept.
    always_comb begin
        xor_rd = '0;
        xor_wr = '0;
        for (int j = 0; j < Q; j++) begin
            xor_rd = xor_rd ^ mem_rd_data[j*DATA_W +: DATA_W];
            xor_wr = xor_wr ^ mem_wr_data[j*DATA_W +: DATA_W];
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_rd_en && !mem_wr_en));

    p_values_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (xor_wr == $past(xor_rd)));

    p_zero_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_data[DATA_W-1:0] == $past(mem_rd_data[DATA_W-1:0])));

    p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_write_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 (mem_wr_en && (mem_addr == $past(mem_addr, 2))));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_rd_en && !mem_wr_en));

endmodule

bind edge_perm_unit edge_perm_checker #(
    .GF_M   (GF_M),
    .DATA_W (DATA_W),
    .EDGE_W (EDGE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .mem_addr    (mem_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_data (mem_rd_data),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_data (mem_wr_data)
);

// File: tb/edge_perm_unit_bench.sv
module edge_perm_unit_bench;

    localparam int GF_M   = 3;
    localparam int DATA_W = 8;
    localparam int EDGE_W = 8;
    localparam int Q      = 1 << GF_M;
    localparam int NE     = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                mode = 1'b0;
    logic [EDGE_W-1:0]   n_edges = '0;
    logic                busy, done;
    logic [EDGE_W-1:0]   coef_addr, mem_addr;
    logic [GF_M-1:0]     coef_exp;
    logic                mem_rd_en, mem_wr_en;
    logic [Q*DATA_W-1:0] mem_rd_data, mem_wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DATA_W-1:0] mem [NE][Q];
    logic [DATA_W-1:0] orig [NE][Q];
    logic [DATA_W-1:0] expv [NE][Q];
    logic [GF_M-1:0]   lut [NE];
    int bexp [Q];
    int blog [Q];
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit order_ok = 1;

    always #5 clk = ~clk;

    edge_perm_unit #(.GF_M(GF_M), .DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_edge_perm_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .n_edges(n_edges),
        .busy(busy), .done(done), .coef_addr(coef_addr), .coef_exp(coef_exp),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
    );

    // Banked memory and coefficient table with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            for (int j = 0; j < Q; j++) mem_rd_data[j*DATA_W +: DATA_W] <= mem[mem_addr][j];
            coef_exp <= lut[coef_addr];
            rd_cnt = rd_cnt + 1;
        end
        if (mem_wr_en) begin
            for (int j = 0; j < Q; j++) mem[mem_addr][j] <= mem_wr_data[j*DATA_W +: DATA_W];
            if (int'(mem_addr) != wr_cnt) order_ok = 0;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bmul(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return bexp[(blog[a] + blog[b]) % (Q-1)];
    endfunction

    task automatic fill(input int seed);
        for (int e = 0; e < NE; e++)
            for (int j = 0; j < Q; j++) begin
                mem[e][j] = DATA_W'(seed + e*17 + j*29);
                orig[e][j] = mem[e][j];
            end
    endtask

    // Expected result: scatter each source lane to its product position.
    task automatic build_expect(input bit depermute, input int n);
        for (int e = 0; e < NE; e++) begin
            int k, h;
            k = int'(lut[e]) % (Q-1);
            if (depermute) k = (Q-1-k) % (Q-1);
            h = bexp[k];
            for (int x = 0; x < Q; x++) begin
                if (e < n) expv[e][bmul(h, x)] = orig[e][x];
                else expv[e][x] = orig[e][x];
            end
        end
    endtask

    task automatic compare(input string req);
        int bad;
        bad = 0;
        for (int e = 0; e < NE; e++)
            for (int j = 0; j < Q; j++)
                if (mem[e][j] !== expv[e][j]) begin
                    if (bad == 0)
                        chk(0, req, int'(mem[e][j]), int'(expv[e][j]));
                    bad++;
                end
        if (bad == 0) chk(1, req, 0, 0);
    endtask

    task automatic run(input logic md, input int n, input bit hold, output int cyc);
        wr_cnt = 0; rd_cnt = 0; order_ok = 1;
        @(negedge clk); mode = md; n_edges = EDGE_W'(n); start = 1'b1;
        @(negedge clk); if (!hold) start = 1'b0;
        cyc = 0;
        while (!done) begin @(negedge clk); cyc++; end
        if (hold) begin @(posedge clk); #1 start = 1'b0; end
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(busy == 0 && done == 0, "R1 busy/done", int'({busy, done}), 0);
        chk(mem_rd_en == 0 && mem_wr_en == 0, "R1 mem strobes", int'({mem_rd_en, mem_wr_en}), 0);
    endtask

    task automatic t_permute;
        int cyc;
        fill(3);
        for (int e = 0; e < NE; e++) lut[e] = GF_M'(e);   // exps 0 and 7 give identity (R5)
        build_expect(0, NE);
        run(1'b0, NE, 0, cyc);
        compare("R2 permute data");
        chk(mem[0][1] == orig[0][1] && mem[7][5] == orig[7][5], "R5 identity edges", int'(mem[7][5]), int'(orig[7][5]));
        chk(mem[3][0] == orig[3][0], "R4 zero lane", int'(mem[3][0]), int'(orig[3][0]));
        chk(cyc == 3*NE, "R7 done timing", cyc, 3*NE);
        chk(wr_cnt == NE && rd_cnt == NE && order_ok, "R6 access order", wr_cnt, NE);
        chk(done == 0 && busy == 0, "R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_restore;
        int cyc;
        for (int e = 0; e < NE; e++)
            for (int j = 0; j < Q; j++) expv[e][j] = orig[e][j];
        run(1'b1, NE, 0, cyc);
        compare("R3 depermute restores");
    endtask

    task automatic t_depermute_direct;
        int cyc;
        fill(101);
        for (int e = 0; e < NE; e++) lut[e] = GF_M'((e * 3 + 2) % Q);
        build_expect(1, 5);
        run(1'b1, 5, 0, cyc);
        compare("R3 depermute data");
        chk(cyc == 15, "R7 done timing n=5", cyc, 15);
        chk(wr_cnt == 5 && order_ok, "R6 partial run", wr_cnt, 5);
    endtask

    task automatic t_zero_edges;
        int cyc;
        fill(55);
        build_expect(0, 0);
        run(1'b0, 0, 0, cyc);
        chk(cyc == 0, "R7 zero edges timing", cyc, 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R7 zero edges access", wr_cnt + rd_cnt, 0);
        compare("R7 zero edges data");
    endtask

    task automatic t_start_collision;
        int cyc;
        fill(200);
        for (int e = 0; e < NE; e++) lut[e] = GF_M'(1 + e % 6);
        build_expect(0, 4);
        run(1'b0, 4, 1, cyc);
        chk(cyc == 12, "R8 run length with start held", cyc, 12);
        chk(wr_cnt == 4 && order_ok, "R8 no extra writes", wr_cnt, 4);
        chk(busy == 0 && done == 0, "R8 idle after done", int'({busy, done}), 0);
        compare("R8 single reordering");
    endtask

    initial begin
        int v;
        v = 1;
        for (int i = 0; i < Q-1; i++) begin
            bexp[i] = v;
            blog[v] = i;
            v = v << 1;
            if (v & Q) v = (v ^ Q) ^ 3;
        end
        blog[0] = 0;
        for (int e = 0; e < NE; e++) lut[e] = '0;
        fill(0);
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_permute();
        t_restore();
        t_depermute_direct();
        t_zero_edges();
        t_start_collision();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule